// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Controller

This block sits between a synchronous host request port and a 1M x 16 asynchronous EDO DRAM. The host offers one word request at a time. Each request carries a 20-bit word address, 16-bit write data, two byte enables and a read/write flag, and is taken on a valid/ready handshake. The controller splits the address into a 10-bit row (upper bits) and a 10-bit column (lower bits). Both halves go out on one shared multiplexed address bus. The controller drives the row strobe, one column strobe per byte lane, write enable and output enable, plus a bidirectional data bus. Read data returns on a one-cycle response pulse.

A row stays open after its first access. Later requests to the same row are served by column strobes alone, which is page mode. A request to a different row, a refresh grant, or a row that has been open too long closes the row and waits out precharge. Every analog timing limit is given as a parameter counted in controller clock cycles, rounded up from nanoseconds.

The state machine has nine states:
- IDLE: row strobe high, precharge done.
- ROWSET: row address driven, row strobe still high.
- RCD: row strobe low, waiting out the row-to-column delay.
- OPEN: row open, column strobes high.
- COLSET: column address, write enable and write data set up.
- STROBE: column strobes low.
- CPRE: column precharge.
- CLOSE: row strobe held low until the minimum row-strobe width has passed.
- PRE: row precharge.

The transitions are:
- *open* (IDLE to ROWSET on a request with no grant).
- *latch-row* (ROWSET to RCD).
- *ready* (RCD to OPEN).
- *hit* (OPEN to COLSET on an accepted same-row request).
- *fire* (COLSET to STROBE).
- *done* (STROBE to CPRE).
- *recover* (CPRE to OPEN).
- *evict* (OPEN to CLOSE on a row miss, a grant or the open-time limit).
- *release* (CLOSE to PRE).
- *rest* (PRE to IDLE).
- *abort* (ROWSET to IDLE when a grant arrives).

Top module: `edo_page_ctrl`

## Requirements
- R1: While reset is held, and after it until the first request, the row strobe, both column strobes, write enable and output enable are high. The data bus is not driven, and req_ready and rsp_valid are low.
- R2: The row is address bits [19:10] and the column is bits [9:0]. The row is on dram_addr when the row strobe falls, and the column is on dram_addr when a column strobe falls.
- R3: A read returns the word last written to that address (zero if never written) on rsp_rdata, with rsp_valid high for exactly one cycle.
- R4: dram_cas_n bit 1 is the upper byte (data bits 15:8) and bit 0 is the lower byte. A write strobes only the lanes whose req_be bit is 1. A read strobes both lanes.
- R5: Requests to the row already open are served with no new fall of the row strobe.
- R6: A request to another row raises the row strobe, waits the precharge, and opens the new row, giving exactly one new row-strobe fall per row change.
- R7: While ref_grant is high, req_ready stays low. The open row is closed and the row strobe stays high. Stored data is kept.
- R8: An open row is closed once it has been open RAS_OPEN_MAX cycles. The row strobe is never low for more than RAS_OPEN_MAX plus one access and one column precharge.
- R9: Minimum timings hold in cycles:
  - row strobe low at least T_RAS;
  - row strobe high at least T_RP;
  - row fall to first column fall at least T_RCD;
  - column strobe low at least T_CAS;
  - column strobe high between strobes in a row at least T_CP.
- R10: Writes are early writes. Write enable is low, and data is driven and valid, from at least one cycle before the column strobe falls. Output enable stays high whenever write enable is low.
- R11: Read data is sampled only after T_CAC cycles of column strobe low, T_RAC cycles of row strobe low, T_OAC cycles of output enable low, and T_CAA cycles since the column address was driven.
- R12: The controller drives the data bus only in the COLSET and STROBE states of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address: row [19:10], column [9:0] |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 upper byte |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | 16 | Read data |
| ref_grant | input | 1 | Refresh grant: close row and hold it closed |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 2 | Column strobes per byte lane, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq | inout | 16 | Bidirectional data bus |

## Verification
The bench uses a behavioural DRAM model that latches the row and column on the strobe edges. Until the column and row access counts have passed, the model returns a poison word, so a controller that samples early returns wrong read data. Page hits and misses are told apart by counting row-strobe falls. A controller that reopened the row on every access, or missed a row change, shows a wrong fall count. Byte-lane writes are read back merged, which exposes a strobe on the wrong lane. Monitors also check:
- each strobe width and gap, caught by a controller that leaves a state one cycle early;
- write enable and data ahead of the column strobe;
- the grant hold, and the forced close after the open-time limit, which a missing close would leave open.

// File: rtl/edo_pkg.sv
package edo_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROWSET,
        ST_RCD,
        ST_OPEN,
        ST_COLSET,
        ST_STROBE,
        ST_CPRE,
        ST_CLOSE,
        ST_PRE
    } edo_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/edo_state_timer.sv
module edo_state_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);

    // Cycles spent in the current state: zero in the first cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            count <= '0;
        end else if (count != {CNT_W{1'b1}}) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/edo_ras_window.sv
module edo_ras_window #(
    parameter int T_RAS    = 13,
    parameter int T_RAC    = 13,
    parameter int OPEN_MAX = 40000,
    parameter int BOUND    = 40100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_low,
    output logic min_met,
    output logic rac_met,
    output logic max_hit
);

    localparam int CW = $clog2(BOUND + 2) + 1;
    localparam logic [CW-1:0] MIN_END = CW'(T_RAS - 1);
    localparam logic [CW-1:0] RAC_END = CW'(T_RAC - 1);
    localparam logic [CW-1:0] MAX_END = CW'(OPEN_MAX);

    logic [CW-1:0] low_cnt;

    // Counts cycles of row strobe low; zero in the first low cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !ras_low) begin
            low_cnt <= '0;
        end else if (low_cnt != {CW{1'b1}}) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign min_met = (low_cnt >= MIN_END);
    assign rac_met = (low_cnt >= RAC_END);
    assign max_hit = (low_cnt >= MAX_END);

    // R8
    ras_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ras_low |-> (low_cnt <= CW'(BOUND)));

endmodule

// File: rtl/edo_cas_lanes.sv
module edo_cas_lanes #(
    parameter int LANES = 2
) (
    input  logic             strobe,
    input  logic             is_write,
    input  logic [LANES-1:0] be,
    output logic [LANES-1:0] cas_n
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Reads use every lane; writes only the enabled lanes.
        assign cas_n[l] = !(strobe && (!is_write || be[l]));
    end

endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
    import edo_pkg::*;
#(
    parameter int ROW_W        = 10,
    parameter int COL_W        = 10,
    parameter int DQ_W         = 16,
    parameter int T_RCD        = 3,
    parameter int T_CAS        = 2,
    parameter int T_CP         = 2,
    parameter int T_RP         = 8,
    parameter int T_RAS        = 13,
    parameter int T_RAC        = 13,
    parameter int T_CAC        = 4,
    parameter int T_OAC        = 4,
    parameter int T_CAA        = 7,
    parameter int RAS_OPEN_MAX = 40000
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      req_valid,
    output logic                                      req_ready,
    input  logic                                      req_write,
    input  logic [ROW_W+COL_W-1:0]                    req_addr,
    input  logic [DQ_W-1:0]                           req_wdata,
    input  logic [DQ_W/8-1:0]                         req_be,
    output logic                                      rsp_valid,
    output logic [DQ_W-1:0]                           rsp_rdata,
    input  logic                                      ref_grant,
    output logic [(ROW_W > COL_W ? ROW_W : COL_W)-1:0] dram_addr,
    output logic                                      dram_ras_n,
    output logic [DQ_W/8-1:0]                         dram_cas_n,
    output logic                                      dram_we_n,
    output logic                                      dram_oe_n,
    inout  wire  [DQ_W-1:0]                           dram_dq
);

    localparam int LANES   = DQ_W / 8;
    localparam int A_W     = imax(ROW_W, COL_W);
    localparam int RD_HOLD = imax(imax(T_CAS, T_CAC), imax(T_OAC, T_CAA - 1));
    localparam int T_LONG  = imax(imax(RD_HOLD, T_RP), imax(T_CP, T_RCD));
    localparam int ST_W    = $clog2(T_LONG + 1) + 1;
    localparam int BOUND   = imax(RAS_OPEN_MAX + RD_HOLD + T_CP + 4,
                                  T_RAS + T_RCD + RD_HOLD + T_CP + 8);

    localparam logic [ST_W-1:0] RCD_END = ST_W'(T_RCD - 1);
    localparam logic [ST_W-1:0] WR_END  = ST_W'(T_CAS - 1);
    localparam logic [ST_W-1:0] RD_END  = ST_W'(RD_HOLD - 1);
    localparam logic [ST_W-1:0] CP_END  = ST_W'(T_CP - 1);
    localparam logic [ST_W-1:0] RP_END  = ST_W'(T_RP - 1);

    edo_state_e state_q, state_d;

    logic [ST_W-1:0]  st_cnt;
    logic             ras_min_met, ras_rac_met, ras_max_hit;
    logic [ROW_W-1:0] open_row_q;
    logic [COL_W-1:0] acc_col_q;
    logic             acc_wr_q;
    logic [LANES-1:0] acc_be_q;
    logic [DQ_W-1:0]  acc_wd_q;
    logic             row_hit, accept, strobe_done;
    logic             strobe, dq_drive;
    logic             rsp_valid_q;
    logic [DQ_W-1:0]  rsp_rdata_q;

    wire [ROW_W-1:0] req_row = req_addr[ROW_W+COL_W-1:COL_W];
    wire [COL_W-1:0] req_col = req_addr[COL_W-1:0];

    assign row_hit   = (req_row == open_row_q);
    assign req_ready = (state_q == ST_OPEN) && row_hit && !ref_grant && !ras_max_hit;
    assign accept    = req_ready && req_valid;

    assign strobe_done = acc_wr_q ? (st_cnt >= WR_END)
                                  : ((st_cnt >= RD_END) && ras_rac_met);

    edo_state_timer #(.CNT_W(ST_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_d != state_q),
        .count   (st_cnt)
    );

    edo_ras_window #(
        .T_RAS    (T_RAS),
        .T_RAC    (T_RAC),
        .OPEN_MAX (RAS_OPEN_MAX),
        .BOUND    (BOUND)
    ) u_ras_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .ras_low (!dram_ras_n),
        .min_met (ras_min_met),
        .rac_met (ras_rac_met),
        .max_hit (ras_max_hit)
    );

    edo_cas_lanes #(.LANES(LANES)) u_lanes (
        .strobe   (strobe),
        .is_write (acc_wr_q),
        .be       (acc_be_q),
        .cas_n    (dram_cas_n)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid && !ref_grant) state_d = ST_ROWSET;
            ST_ROWSET: state_d = ref_grant ? ST_IDLE : ST_RCD;
            ST_RCD:    if (st_cnt >= RCD_END) state_d = ST_OPEN;
            ST_OPEN: begin
                if (ref_grant || ras_max_hit || (req_valid && !row_hit)) begin
                    state_d = ST_CLOSE;
                end else if (accept) begin
                    state_d = ST_COLSET;
                end
            end
            ST_COLSET: state_d = ST_STROBE;
            ST_STROBE: if (strobe_done) state_d = ST_CPRE;
            ST_CPRE:   if (st_cnt >= CP_END) state_d = ST_OPEN;
            ST_CLOSE:  if (ras_min_met) state_d = ST_PRE;
            ST_PRE:    if (st_cnt >= RP_END) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Row and access latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_row_q <= '0;
            acc_col_q  <= '0;
            acc_wr_q   <= 1'b0;
            acc_be_q   <= '0;
            acc_wd_q   <= '0;
        end else begin
            if (state_q == ST_IDLE && state_d == ST_ROWSET) open_row_q <= req_row;
            if (accept) begin
                acc_col_q <= req_col;
                acc_wr_q  <= req_write;
                acc_be_q  <= req_be;
                acc_wd_q  <= req_wdata;
            end
        end
    end

    // Read capture at the end of the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            if (state_q == ST_STROBE && strobe_done && !acc_wr_q) begin
                rsp_valid_q <= 1'b1;
                rsp_rdata_q <= dram_dq;
            end
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rsp_rdata_q;

    // Output decode
    always_comb begin
        dram_ras_n = 1'b1;
        dram_we_n  = 1'b1;
        dram_oe_n  = 1'b1;
        strobe     = 1'b0;
        dq_drive   = 1'b0;
        dram_addr  = A_W'(open_row_q);
        unique case (state_q)
            ST_IDLE, ST_ROWSET, ST_PRE: ;
            ST_RCD, ST_OPEN, ST_CLOSE: dram_ras_n = 1'b0;
            ST_COLSET: begin
                dram_ras_n = 1'b0;
                dram_addr  = A_W'(acc_col_q);
                dram_we_n  = !acc_wr_q;
                dq_drive   = acc_wr_q;
            end
            ST_STROBE: begin
                dram_ras_n = 1'b0;
                dram_addr  = A_W'(acc_col_q);
                dram_we_n  = !acc_wr_q;
                dram_oe_n  = acc_wr_q;
                dq_drive   = acc_wr_q;
                strobe     = 1'b1;
            end
            ST_CPRE: begin
                dram_ras_n = 1'b0;
                dram_addr  = A_W'(acc_col_q);
            end
            default: ;
        endcase
    end

    assign dram_dq = dq_drive ? acc_wd_q : {DQ_W{1'bz}};

    // R9
    ras_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_ras_n && $past(!dram_ras_n)) |-> $past(ras_min_met));

    // R10
    early_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&dram_cas_n) && $past(&dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n));

    // R10
    oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> dram_oe_n);

    // R7
    grant_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_grant |-> !req_ready);

    // R5
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_ras_n && $past(!dram_ras_n)) |-> $stable(open_row_q));

    // R4
    lane_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STROBE && acc_wr_q) |-> ((~dram_cas_n & ~acc_be_q) == '0));

endmodule

// File: tb/edo_page_ctrl_bench.sv
module edo_page_ctrl_bench;

    localparam int T_RCD   = 3;
    localparam int T_CAS   = 2;
    localparam int T_CP    = 2;
    localparam int T_RP    = 8;
    localparam int T_RAS   = 13;
    localparam int T_RAC   = 13;
    localparam int T_CAC   = 4;
    localparam int T_OAC   = 4;
    localparam int T_CAA   = 7;
    localparam int OPEN_MX = 200;
    localparam int NV      = 12;

    // {write, addr[19:0], data[15:0], be[1:0]}
    localparam logic [38:0] VEC [NV] = '{
        {1'b1, 20'h12345, 16'hA1B2, 2'b11},
        {1'b1, 20'h12346, 16'hC3D4, 2'b11},
        {1'b0, 20'h12345, 16'h0000, 2'b11},
        {1'b0, 20'h12346, 16'h0000, 2'b11},
        {1'b1, 20'h12347, 16'h5566, 2'b11},
        {1'b1, 20'h12347, 16'h1299, 2'b01},
        {1'b1, 20'h12347, 16'h7734, 2'b10},
        {1'b0, 20'h12347, 16'h0000, 2'b11},
        {1'b1, 20'h3FF00, 16'hBEEF, 2'b11},
        {1'b0, 20'h12345, 16'h0000, 2'b11},
        {1'b0, 20'h3FF00, 16'h0000, 2'b11},
        {1'b0, 20'h00000, 16'h0000, 2'b11}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, ref_grant = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [9:0]  dram_addr;
    logic        dram_ras_n, dram_we_n, dram_oe_n;
    logic [1:0]  dram_cas_n;
    wire  [15:0] dram_dq;

    always #2 clk = ~clk;

    edo_page_ctrl #(
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP), .T_RAS(T_RAS),
        .T_RAC(T_RAC), .T_CAC(T_CAC), .T_OAC(T_OAC), .T_CAA(T_CAA),
        .RAS_OPEN_MAX(OPEN_MX)
    ) u_edo_page_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ref_grant(ref_grant),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq(dram_dq)
    );

    int errors = 0, checks = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- DRAM model ----------------
    logic [15:0] mem [logic [19:0]];
    logic [15:0] exp_mem [logic [19:0]];
    logic [9:0]  row_l = '0, col_l = '0;
    logic [1:0]  lane_seen = '0;
    logic [15:0] mdl_q = 16'hBAD0;
    int ras_lo = 0, ras_hi = 1000, cas_lo = 0, cas_hi = 1000, max_lo = 0;
    int ras_falls = 0, tm_bad = 0, we_bad = 0, writes_seen = 0;
    logic prev_ras = 1'b1, prev_cas = 1'b1, first_cas = 1'b1, we_prev = 1'b1;

    function automatic logic [15:0] rd_mem(input logic [19:0] k);
        return mem.exists(k) ? mem[k] : 16'h0000;
    endfunction

    function automatic logic [15:0] rd_exp(input logic [19:0] k);
        return exp_mem.exists(k) ? exp_mem[k] : 16'h0000;
    endfunction

    assign dram_dq = (!dram_ras_n && !(&dram_cas_n) && !dram_oe_n && dram_we_n) ? mdl_q : 16'hzzzz;

    always @(negedge dram_ras_n) row_l = dram_addr;

    always @(negedge dram_cas_n[0] or negedge dram_cas_n[1]) begin
        if (rst_n && !dram_ras_n) begin
            logic [15:0] t;
            col_l = dram_addr;
            lane_seen = lane_seen | ~dram_cas_n;
            if (!dram_we_n) begin
                writes_seen++;
                if (we_prev !== 1'b0 || dram_oe_n !== 1'b1 || (^dram_dq) === 1'bx) we_bad++;
                t = rd_mem({row_l, col_l});
                if (!dram_cas_n[1]) t[15:8] = dram_dq[15:8];
                if (!dram_cas_n[0]) t[7:0]  = dram_dq[7:0];
                mem[{row_l, col_l}] = t;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic cl;
            cl = !(&dram_cas_n);
            if (!dram_ras_n) begin
                if (prev_ras) begin
                    ras_falls++;
                    if (ras_hi < T_RP) tm_bad++;
                    ras_lo = 1;
                    first_cas = 1'b1;
                end else ras_lo++;
            end else begin
                if (!prev_ras) begin
                    if (ras_lo < T_RAS) tm_bad++;
                    if (ras_lo > max_lo) max_lo = ras_lo;
                    ras_hi = 1;
                end else ras_hi++;
            end
            if (cl) begin
                if (prev_cas) begin
                    if (first_cas) begin
                        if (ras_lo - 1 < T_RCD) tm_bad++;
                        first_cas = 1'b0;
                    end else if (cas_hi < T_CP) tm_bad++;
                    cas_lo = 1;
                end else cas_lo++;
            end else begin
                if (!prev_cas) begin
                    if (cas_lo < T_CAS) tm_bad++;
                    cas_hi = 1;
                end else cas_hi++;
            end
            if (!dram_we_n && !dram_oe_n) we_bad++;
            mdl_q = (cl && cas_lo >= T_CAC && ras_lo >= T_RAC) ? rd_mem({row_l, col_l}) : 16'hBAD0;
            we_prev  = dram_we_n;
            prev_ras = dram_ras_n;
            prev_cas = cl ? 1'b0 : 1'b1;
        end
    end

    // ---------------- Host driver ----------------
    task automatic do_op(input logic w, input logic [19:0] a, input logic [15:0] d,
                         input logic [1:0] be, output logic [15:0] rd);
        int t;
        rd = '0;
        @(negedge clk);
        lane_seen = '0;
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
        #1;
        t = 0;
        while (!req_ready && t < 2000) begin
            @(negedge clk); #1; t++;
        end
        chk(t < 2000, "R5 request accepted", 32'(t), 32'd0);
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (!w) begin
            t = 0;
            @(negedge clk);
            while (!rsp_valid && t < 2000) begin
                @(negedge clk); t++;
            end
            rd = rsp_rdata;
            @(negedge clk);
            chk(!rsp_valid && t < 2000, "R3 one-cycle response", 32'(rsp_valid), 32'd0);
        end else begin
            repeat (T_CAS + 3) @(negedge clk);
            t = 0;
            while (!(&dram_cas_n) && t < 50) begin @(negedge clk); t++; end
        end
        chk(row_l == a[19:10] && col_l == a[9:0], "R2 row/column split",
            32'({row_l, col_l}), 32'(a));
    endtask

    // ---------------- Sequence ----------------
    initial begin
        logic [15:0] rd, e;
        int f0, f7;
        repeat (4) @(negedge clk);
        chk(dram_ras_n && (&dram_cas_n) && dram_we_n && dram_oe_n && !req_ready && !rsp_valid
            && dram_dq === 16'hzzzz, "R1 reset outputs",
            {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, req_ready, rsp_valid}, 32'h7c);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(dram_ras_n && (&dram_cas_n) && dram_we_n && dram_oe_n && !req_ready
            && dram_dq === 16'hzzzz, "R1 idle after reset",
            {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 32'h1f);

        f0 = ras_falls;
        f7 = 0;
        for (int i = 0; i < NV; i++) begin
            logic        w;
            logic [19:0] a;
            logic [15:0] d;
            logic [1:0]  be;
            {w, a, d, be} = VEC[i];
            if (w) begin
                e = rd_exp(a);
                if (be[1]) e[15:8] = d[15:8];
                if (be[0]) e[7:0]  = d[7:0];
                exp_mem[a] = e;
            end
            do_op(w, a, d, be, rd);
            if (w) chk(lane_seen == be, "R4 write lanes", 32'(lane_seen), 32'(be));
            else begin
                chk(lane_seen == 2'b11, "R4 read lanes", 32'(lane_seen), 32'h3);
                chk(rd == rd_exp(a), "R3 R11 read data", 32'(rd), 32'(rd_exp(a)));
            end
            if (i == 7) begin
                chk(ras_falls - f0 == 1, "R5 page hits keep row", 32'(ras_falls - f0), 32'd1);
                f7 = ras_falls;
            end
        end
        chk(ras_falls - f7 == 4, "R6 one open per row change", 32'(ras_falls - f7), 32'd4);

        // R7 refresh grant
        exp_mem[20'h12345] = 16'h0F0F;
        do_op(1'b1, 20'h12345, 16'h0F0F, 2'b11, rd);
        @(negedge clk);
        ref_grant = 1'b1;
        repeat (40) @(negedge clk);
        chk(dram_ras_n, "R7 grant closes row", 32'(dram_ras_n), 32'd1);
        begin
            int rdy = 0, lo = 0;
            req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h12345; req_be = 2'b11;
            repeat (30) begin
                @(negedge clk);
                if (req_ready) rdy++;
                if (!dram_ras_n) lo++;
            end
            chk(rdy == 0 && lo == 0, "R7 grant blocks requests", 32'(rdy + lo), 32'd0);
            req_valid = 1'b0;
        end
        ref_grant = 1'b0;
        do_op(1'b0, 20'h12345, 16'h0, 2'b11, rd);
        chk(rd == 16'h0F0F, "R7 data kept across grant", 32'(rd), 32'h0F0F);

        // R8 open-time limit
        do_op(1'b0, 20'h00400, 16'h0, 2'b11, rd);
        chk(rd == 16'h0000, "R3 unwritten word", 32'(rd), 32'd0);
        repeat (300) @(negedge clk);
        chk(dram_ras_n, "R8 idle row closed", 32'(dram_ras_n), 32'd1);
        chk(max_lo >= OPEN_MX && max_lo <= OPEN_MX + 14, "R8 open-time bound",
            32'(max_lo), 32'(OPEN_MX));

        chk(tm_bad == 0, "R9 strobe timings", 32'(tm_bad), 32'd0);
        chk(we_bad == 0 && writes_seen > 0, "R10 R12 early write", 32'(we_bad), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        chk(1'b0, "watchdog", 32'd1, 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule